// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, weekday, day of month, month, two-digit year and a century byte. Hidden counters advance on every cycle where the 1 Hz enable is high. The bytes that software sees are separate copy registers at the top of a byte-addressed space. They are refreshed from the counters on each tick, so a read never observes a counter part-way through a carry.

A control byte lets software stop the refresh. The hold bit holds the visible bytes still while time keeps running, which gives a consistent snapshot to read. The freeze bit also stops the refresh. Any time byte written while freeze is set is loaded into the counters when freeze is cleared, so several fields can be set at once. The low six control bits hold a signed trim value that is only stored and read back.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After a synchronous reset, the visible bytes read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00, century 00 and control 00. The read data output is 00.
- R2: With TOP the all-ones address, the map is: seconds TOP-6, minutes TOP-5, hours TOP-4, weekday TOP-3, date TOP-2, month TOP-1, year TOP, control TOP-7 and century TOP-14. Read data is registered and shows the addressed byte one cycle after the address. Any other address reads 00, and writes to it change nothing.
- R3: Seconds and minutes count 00–59 and hours count 00–23, each carrying into the next field. The weekday counts 1–7 and steps on the midnight carry, wrapping from 7 to 1.
- R4: Months 04, 06, 09 and 11 end after date 30. Every other month except 02 ends after date 31. The midnight after the last date gives date 01 of the next month.
- R5: Month 02 ends after date 29 when the year's BCD value is divisible by 4 (year 00 included). Otherwise it ends after date 28.
- R6: Month 12 rolls to 01 and increments the year. Year 99 rolls to 00 and increments the century, which wraps from 99 to 00.
- R7: On the clock edge where the tick enable is high, with control bits 7 and 6 clear, the counters advance one second. The visible bytes take the advanced time on that same edge.
- R8: While control bit 6 (hold) is 1, the visible bytes do not change except by bus writes, and the counters keep running. After bit 6 is cleared, the next tick shows the true time.
- R9: While control bit 7 (freeze) is 1, the visible bytes are not refreshed. Time bytes written during freeze are loaded into the counters when control is written with bit 7 = 0. Unwritten fields keep their running count. A tick in that release cycle is dropped.
- R10: Control bits 5:0 (bit 5 sign, bits 4:0 magnitude) are stored, read back unchanged, and do not affect counting.
- R11: With bit 7 clear, writing a time byte changes only its visible copy, and the next refresh overwrites it. A write in the same cycle as a refresh takes precedence for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The main function is tried with a long run of consecutive ticks, which crosses many minute and hour carries while the read address rotates over every location. It is also tried with preset instants just before each calendar boundary: a 30-day month end, February in leap and common years including year 00, year end with a century carry, and the weekday wrap. Each preset separates one month-length or carry rule from the others. Hold and freeze sequences with ticks in between tell the visible copies apart from the running counters. A tick in the release cycle and a write that lands on a refresh pin down the priority rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NFIELD = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;
  localparam int F_CEN  = 7;

  typedef logic [7:0] bcd_t;

  typedef struct packed {
    bcd_t cen;
    bcd_t yr;
    bcd_t mon;
    bcd_t date;
    bcd_t wday;
    bcd_t hr;
    bcd_t min;
    bcd_t sec;
  } rtc_time_t;

  localparam rtc_time_t RST_TIME = '{cen: 8'h00, yr: 8'h00, mon: 8'h01,
                                     date: 8'h01, wday: 8'h01, hr: 8'h00,
                                     min: 8'h00, sec: 8'h00};

  function automatic bcd_t bcd_inc(bcd_t b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'h1, 4'h0};
    return {b[7:4], b[3:0] + 4'h1};
  endfunction

  function automatic logic year_is_leap(bcd_t y);
    logic [6:0] v;
    v = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (v[1:0] == 2'b00);
  endfunction

  function automatic bcd_t month_end(bcd_t mon, bcd_t yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
  import rtc_pkg::*;
(
  input  rtc_time_t now_t,
  output rtc_time_t next_t
);

  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    next_t = now_t;
    c_min  = (now_t.sec == 8'h59);
    c_hr   = c_min && (now_t.min == 8'h59);
    c_day  = c_hr && (now_t.hr == 8'h23);
    c_mon  = c_day && (now_t.date == month_end(now_t.mon, now_t.yr));
    c_yr   = c_mon && (now_t.mon == 8'h12);
    c_cen  = c_yr && (now_t.yr == 8'h99);

    next_t.sec = c_min ? 8'h00 : bcd_inc(now_t.sec);
    if (c_min) next_t.min = c_hr ? 8'h00 : bcd_inc(now_t.min);
    if (c_hr)  next_t.hr  = c_day ? 8'h00 : bcd_inc(now_t.hr);
    if (c_day) begin
      next_t.wday = (now_t.wday == 8'h07) ? 8'h01 : bcd_inc(now_t.wday);
      next_t.date = c_mon ? 8'h01 : bcd_inc(now_t.date);
    end
    if (c_mon) next_t.mon = c_yr ? 8'h01 : bcd_inc(now_t.mon);
    if (c_yr)  next_t.yr  = c_cen ? 8'h00 : bcd_inc(now_t.yr);
    if (c_cen) next_t.cen = (now_t.cen == 8'h99) ? 8'h00 : bcd_inc(now_t.cen);
  end

endmodule

// File: rtl/rtc_counter_core.sv
module rtc_counter_core
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [NFIELD-1:0] load_mask,
  input  rtc_time_t         load_val,
  output rtc_time_t         cur_t,
  output rtc_time_t         nxt_t
);

  rtc_next_time u_next (
    .now_t  (cur_t),
    .next_t (nxt_t)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_t <= RST_TIME;
    end else if (load) begin
      for (int i = 0; i < NFIELD; i++)
        if (load_mask[i]) cur_t[8*i +: 8] <= load_val[8*i +: 8];
    end else if (tick) begin
      cur_t <= nxt_t;
    end
  end

  assert_tick_advances_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (cur_t != $past(cur_t)));

  assert_idle_counters_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cur_t));

  assert_second_wraps_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cur_t.sec == 8'h59) |=> (cur_t.sec == 8'h00));

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int TIME_OFS = 6,
  parameter int CTL_OFS  = 7,
  parameter int CENT_OFS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = TOP_ADDR - ADDR_W'(CTL_OFS);
  localparam int B_FREEZE = 7;
  localparam int B_HOLD   = 6;

  function automatic logic [ADDR_W-1:0] field_addr(int i);
    if (i == F_CEN) return TOP_ADDR - ADDR_W'(CENT_OFS);
    return TOP_ADDR - ADDR_W'(TIME_OFS - i);
  endfunction

  logic [7:0]        vis [NFIELD];
  logic [7:0]        ctl;
  logic [NFIELD-1:0] dirty;
  logic [NFIELD-1:0] hit_time;
  logic              hit_ctl;
  logic              refresh, load;
  rtc_time_t         vis_flat, cur_t, nxt_t;
  logic [7:0]        rd_nx;

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      hit_time[i]        = (bus_addr == field_addr(i));
      vis_flat[8*i +: 8] = vis[i];
    end
    hit_ctl = (bus_addr == CTL_ADDR);
  end

  assign refresh = tick_1hz && !ctl[B_FREEZE] && !ctl[B_HOLD];
  assign load    = bus_wr && hit_ctl && ctl[B_FREEZE] && !bus_wdata[B_FREEZE];

  rtc_counter_core u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1hz),
    .load      (load),
    .load_mask (dirty),
    .load_val  (vis_flat),
    .cur_t     (cur_t),
    .nxt_t     (nxt_t)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NFIELD; i++) vis[i] <= RST_TIME[8*i +: 8];
      dirty <= '0;
      ctl   <= 8'h00;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (bus_wr && hit_time[i]) vis[i] <= bus_wdata;
        else if (refresh)          vis[i] <= nxt_t[8*i +: 8];
      end
      if (load) dirty <= '0;
      else if (bus_wr && ctl[B_FREEZE]) dirty <= dirty | hit_time;
      if (bus_wr && hit_ctl) ctl <= bus_wdata;
    end
  end

  always_comb begin
    rd_nx = 8'h00;
    if (hit_ctl) rd_nx = ctl;
    for (int i = 0; i < NFIELD; i++)
      if (hit_time[i]) rd_nx = vis[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_nx;
  end

  assert_copies_held_R8: assert property (@(posedge clk) disable iff (rst)
    ((ctl[B_FREEZE] || ctl[B_HOLD]) && !bus_wr) |=> $stable(vis_flat));

  assert_unmapped_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!(|hit_time) && !hit_ctl) |=> (bus_rdata == 8'h00));

  assert_release_clears_dirty_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (dirty == '0));

endmodule

// File: tb/test_rtc_shadow_bank.sv
module test_rtc_shadow_bank;

  localparam logic [18:0] A_SEC = 19'h7FFF9, A_MIN = 19'h7FFFA, A_HR = 19'h7FFFB,
                          A_WDY = 19'h7FFFC, A_DAT = 19'h7FFFD, A_MON = 19'h7FFFE,
                          A_YR  = 19'h7FFFF, A_CTL = 19'h7FFF8, A_CEN = 19'h7FFF1;

  logic        clk = 0;
  logic        rst = 1;
  logic        tick_1hz = 0;
  logic [18:0] bus_addr = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_shadow_bank i_rtc_shadow_bank (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // reference model: binary counters, BCD visible copies
  int         cnt [8];
  logic [7:0] mvis [8];
  logic [7:0] mctl;
  bit         mdirty [8];

  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int fidx(logic [18:0] a);
    case (a)
      A_SEC: return 0; A_MIN: return 1; A_HR: return 2; A_WDY: return 3;
      A_DAT: return 4; A_MON: return 5; A_YR: return 6; A_CEN: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int days_in(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic void advance();
    cnt[0]++;
    if (cnt[0] < 60) return;
    cnt[0] = 0; cnt[1]++;
    if (cnt[1] < 60) return;
    cnt[1] = 0; cnt[2]++;
    if (cnt[2] < 24) return;
    cnt[2] = 0;
    cnt[3] = (cnt[3] == 7) ? 1 : cnt[3] + 1;
    cnt[4]++;
    if (cnt[4] <= days_in(cnt[5], cnt[6])) return;
    cnt[4] = 1; cnt[5]++;
    if (cnt[5] <= 12) return;
    cnt[5] = 1; cnt[6]++;
    if (cnt[6] <= 99) return;
    cnt[6] = 0;
    cnt[7] = (cnt[7] == 99) ? 0 : cnt[7] + 1;
  endfunction

  function automatic logic [7:0] mread(logic [18:0] a);
    int k = fidx(a);
    if (k >= 0) return mvis[k];
    if (a == A_CTL) return mctl;
    return 8'h00;
  endfunction

  function automatic void mstep(bit t, bit w, logic [18:0] a, logic [7:0] d);
    logic [7:0] octl = mctl;
    int  k = fidx(a);
    bit  ld = 0;
    if (w) begin
      if (k >= 0) begin
        mvis[k] = d;
        if (octl[7]) mdirty[k] = 1;
      end else if (a == A_CTL) begin
        if (octl[7] && !d[7]) begin
          for (int i = 0; i < 8; i++) begin
            if (mdirty[i]) cnt[i] = from_bcd(mvis[i]);
            mdirty[i] = 0;
          end
          ld = 1;
        end
        mctl = d;
      end
    end
    if (t && !ld) begin
      advance();
      if (!octl[7] && !octl[6])
        for (int i = 0; i < 8; i++)
          if (!(w && k == i)) mvis[i] = to_bcd(cnt[i]);
    end
  endfunction

  function automatic void model_reset();
    cnt = '{0, 0, 0, 1, 1, 1, 0, 0};
    for (int i = 0; i < 8; i++) begin
      mvis[i] = to_bcd(cnt[i]);
      mdirty[i] = 0;
    end
    mctl = 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; inputs change after a falling edge, result sampled at the next one
  task automatic cyc(bit t, bit w, logic [18:0] a, logic [7:0] d, string tag);
    logic [7:0] exp;
    tick_1hz = t; bus_wr = w; bus_addr = a; bus_wdata = d;
    exp = mread(a);
    mstep(t, w, a, d);
    @(posedge clk);
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd(logic [18:0] a, string tag);
    cyc(0, 0, a, 8'h00, tag);
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d, string tag);
    cyc(0, 1, a, d, tag);
  endtask

  task automatic tk(logic [18:0] a, string tag);
    cyc(1, 0, a, 8'h00, tag);
  endtask

  task automatic read_all(string tag);
    rd(A_SEC, tag); rd(A_MIN, tag); rd(A_HR, tag); rd(A_WDY, tag);
    rd(A_DAT, tag); rd(A_MON, tag); rd(A_YR, tag); rd(A_CEN, tag);
    rd(A_CTL, tag);
    rd(A_CTL, tag);
  endtask

  task automatic set_time(int c, int y, int mo, int dt, int wd, int h, int mi, int s,
                          string tag);
    wr(A_CTL, 8'h80, tag);
    wr(A_SEC, to_bcd(s), tag);  wr(A_MIN, to_bcd(mi), tag);
    wr(A_HR, to_bcd(h), tag);   wr(A_WDY, to_bcd(wd), tag);
    wr(A_DAT, to_bcd(dt), tag); wr(A_MON, to_bcd(mo), tag);
    wr(A_YR, to_bcd(y), tag);   wr(A_CEN, to_bcd(c), tag);
    wr(A_CTL, 8'h00, tag);
  endtask

  task automatic run_ticks(int n, string tag);
    logic [18:0] ring [10] = '{A_SEC, A_MIN, A_HR, A_WDY, A_DAT, A_MON, A_YR,
                               A_CEN, A_CTL, 19'h00123};
    for (int i = 0; i < n; i++) tk(ring[i % 10], tag);
    read_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    rst = 0;
    read_all("R1 reset values");

    // R2: unmapped locations
    rd(19'h00000, "R2 low address");
    rd(19'h7FFF0, "R2 gap below century");
    wr(19'h7FFF0, 8'h55, "R2 ignored write");
    wr(19'h7FFF7, 8'h66, "R2 ignored write");
    rd(19'h7FFF0, "R2 readback of ignored");
    read_all("R2 map after ignored writes");

    // R10: trim bits
    wr(A_CTL, 8'h3A, "R10 trim write");
    rd(A_CTL, "R10 trim readback");
    run_ticks(12, "R10 counting with trim");
    wr(A_CTL, 8'h25, "R10 trim write");
    rd(A_CTL, "R10 trim readback");
    wr(A_CTL, 8'h00, "R10 trim clear");

    // R3 / R7: long run through minute and hour carries
    run_ticks(3700, "R3 R7 long run");
    set_time(20, 23, 6, 17, 7, 23, 59, 50, "R3 weekday wrap");
    run_ticks(15, "R3 weekday wrap");

    // R4: month ends
    set_time(20, 23, 4, 30, 2, 23, 59, 58, "R4 april end");
    run_ticks(5, "R4 april end");
    set_time(20, 23, 5, 30, 3, 23, 59, 58, "R4 may 30");
    run_ticks(5, "R4 may 31 exists");
    set_time(20, 23, 11, 30, 3, 23, 59, 59, "R4 november end");
    run_ticks(3, "R4 november end");

    // R5: February
    set_time(20, 24, 2, 28, 3, 23, 59, 59, "R5 leap 28");
    run_ticks(3, "R5 leap 29th");
    set_time(20, 24, 2, 29, 4, 23, 59, 59, "R5 leap 29");
    run_ticks(3, "R5 leap to march");
    set_time(20, 23, 2, 28, 2, 23, 59, 59, "R5 common 28");
    run_ticks(3, "R5 common to march");
    set_time(20, 0, 2, 28, 1, 23, 59, 59, "R5 year 00");
    run_ticks(3, "R5 year 00 leap");

    // R6: year and century
    set_time(19, 99, 12, 31, 5, 23, 59, 59, "R6 century carry");
    run_ticks(3, "R6 century carry");
    set_time(99, 99, 12, 31, 6, 23, 59, 58, "R6 century wrap");
    run_ticks(4, "R6 century wrap");

    // R8: hold
    wr(A_CTL, 8'h40, "R8 hold on");
    for (int i = 0; i < 6; i++) tk(A_SEC, "R8 seconds held");
    tk(A_MIN, "R8 minutes held");
    wr(A_CTL, 8'h00, "R8 hold off");
    rd(A_SEC, "R8 stale until tick");
    tk(A_SEC, "R8 catch up");
    read_all("R8 true time");

    // R9: freeze with partial write and release timing
    wr(A_CTL, 8'h80, "R9 freeze on");
    for (int i = 0; i < 5; i++) tk(A_SEC, "R9 frozen copy");
    wr(A_MIN, 8'h30, "R9 write minutes");
    tk(A_MIN, "R9 written value visible");
    wr(A_CTL, 8'h00, "R9 release");
    read_all("R9 after release");
    tk(A_SEC, "R9 refresh after release");
    read_all("R9 loaded minutes kept");
    wr(A_CTL, 8'h80, "R9 freeze on");
    wr(A_HR, 8'h05, "R9 write hours");
    cyc(1, 1, A_CTL, 8'h00, "R9 tick dropped on release");
    tk(A_SEC, "R9 next tick");
    read_all("R9 after dropped tick");

    // R11: plain writes to copies
    wr(A_SEC, 8'h45, "R11 copy write");
    rd(A_SEC, "R11 copy readback");
    tk(A_SEC, "R11 overwritten by refresh");
    cyc(1, 1, A_SEC, 8'h12, "R11 write beats refresh");
    rd(A_SEC, "R11 write won");
    rd(A_MIN, "R11 other fields refreshed");
    tk(A_SEC, "R11 next refresh");
    read_all("R11 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule